// File: doc/BRIEF.md
# Eight-Channel Serial Audio Deserializer

This block turns one serial audio data line into parallel samples for eight channels. It runs entirely in the serial bit-clock domain. Every frame is 256 bit clocks long, so the bit clock runs at 256 times the sample rate. A frame-sync line marks where each frame starts. A static mode input selects one of two framing rules.

In one-line mode the frame sync is high for the first 128 clocks of the frame and low for the last 128. Each half carries four 24-bit slots, and the remaining 32 clocks of each half carry no data. In TDM mode a frame-sync pulse of any width marks the start of the next frame. The pulse is seen one clock before the first MSB, and it is followed by eight packed 32-bit slots.

A static word-length code sets how many leading bits of each slot form the sample. Each completed slot produces one strobed, MSB-aligned 32-bit sample with its channel index. A one-clock error pulse reports a frame sync that arrives at the wrong position. The block then realigns to that frame sync.

Top module: `octal_audio_deser`

## Requirements
- R1: Serial data is captured on the rising bit-clock edge, MSB first. The sample is presented MSB-aligned in a 32-bit word, and every bit below the word length reads zero.
- R2: In one-line mode (`tdm_mode_i`=0), a frame-sync rising edge sampled together with a data bit makes that bit position 0. Positions 0-95 form channels 0-3, 24 bits each. A frame-sync falling edge makes its bit position 128, and positions 128-223 form channels 4-7.
- R3: In one-line mode, positions 96-127 and 224-255 are ignored and produce no sample strobe.
- R4: In TDM mode (`tdm_mode_i`=1), the bit captured on the edge after a frame-sync rising edge is position 0. Slot k occupies positions 32k to 32k+31 and is channel k (k = 0..7). The width of the frame-sync pulse has no effect.
- R5: `wlen_i` encodes the word length as 0=16, 1=18, 2=20, 3=24, and 4 to 7=32 bits. In one-line mode, lengths above 24 act as 24. Slot bits after the word length are discarded.
- R6: `valid_o` is high for exactly one bit clock. It rises on the edge that captures the last bit of a slot (bit 23 in one-line mode, bit 31 in TDM mode). `sample_o` and `chan_o` change only on that edge.
- R7: Once aligned, a frame-sync edge that would start a frame at any position other than 0 gives a one-clock `frame_err_o` pulse. The same applies to a one-line falling edge at any position other than 128. The position counter is then realigned to the new frame sync. The pulse comes on the same edge in one-line mode and one edge later in TDM mode.
- R8: After reset all outputs are zero. Until the first frame-sync edge aligns the counter, no strobe and no error are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tdm_mode_i | input | 1 | 0 = one-line 24-bit slots, 1 = TDM 32-bit slots |
| wlen_i | input | 3 | Word-length code |
| fsync_i | input | 1 | Frame sync |
| sdata_i | input | 1 | Serial data |
| sample_o | output | 32 | MSB-aligned sample |
| chan_o | output | 3 | Channel index of the sample |
| valid_o | output | 1 | One-clock sample strobe |
| frame_err_o | output | 1 | One-clock misplaced frame-sync pulse |

## Verification
A wrong bit position shows at the ports within one slot, as a strobe that fires on the wrong clock or with the wrong channel index. A wrong alignment state shows as a missing or extra error pulse on the very edge the misplaced frame sync is acted on. The bench runs an independent position model that predicts the exact clock of every strobe and error pulse. Any shift by even one bit clock is therefore reported at once, together with corrupted sample bits or non-zero fill bits.

// File: rtl/octal_audio_deser.sv
module octal_audio_deser (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tdm_mode_i,
  input  logic [2:0]  wlen_i,
  input  logic        fsync_i,
  input  logic        sdata_i,
  output logic [31:0] sample_o,
  output logic [2:0]  chan_o,
  output logic        valid_o,
  output logic        frame_err_o
);
  localparam logic [7:0] HALF_POS = 8'd128;

  logic        fs_q, sof_q, locked_q;
  logic [7:0]  pos_q, pos;
  logic [31:0] acc_q, acc_nxt;
  logic [6:0]  off, rel;
  logic [1:0]  ol_slot;
  logic [4:0]  bitn;
  logic [2:0]  ch;
  logic        in_slot, last;
  logic [5:0]  wl;

  wire       fs_rise    = fsync_i & ~fs_q;
  wire       fs_fall    = ~fsync_i & fs_q;
  wire [7:0] pos_inc    = pos_q + 8'd1;
  wire       sync_start = tdm_mode_i ? sof_q : fs_rise;
  wire       sync_half  = ~tdm_mode_i & fs_fall;
  wire       lock_now   = locked_q | sync_start | sync_half;
  wire       misplaced  = locked_q & ((sync_start & (pos_inc != 8'd0)) |
                                      (sync_half & (pos_inc != HALF_POS)));
  wire       emit       = lock_now & in_slot & last;

  always_comb begin
    pos = pos_inc;
    if (sync_start)     pos = 8'd0;
    else if (sync_half) pos = HALF_POS;
  end

  always_comb begin
    case (wlen_i)
      3'd0:    wl = 6'd16;
      3'd1:    wl = 6'd18;
      3'd2:    wl = 6'd20;
      3'd3:    wl = 6'd24;
      default: wl = 6'd32;
    endcase
    if (!tdm_mode_i && wl > 6'd24) wl = 6'd24;
  end

  always_comb begin
    off = pos[6:0];
    if (off >= 7'd72)      begin ol_slot = 2'd3; rel = off - 7'd72; end
    else if (off >= 7'd48) begin ol_slot = 2'd2; rel = off - 7'd48; end
    else if (off >= 7'd24) begin ol_slot = 2'd1; rel = off - 7'd24; end
    else                   begin ol_slot = 2'd0; rel = off;         end
    if (tdm_mode_i) begin
      in_slot = 1'b1;
      ch      = pos[7:5];
      bitn    = pos[4:0];
      last    = (pos[4:0] == 5'd31);
    end else begin
      in_slot = (off < 7'd96);
      ch      = {pos[7], ol_slot};
      bitn    = rel[4:0];
      last    = (rel == 7'd23);
    end
  end

  always_comb begin
    acc_nxt = (bitn == 5'd0) ? 32'd0 : acc_q;
    if ({1'b0, bitn} < wl) acc_nxt[5'd31 - bitn] = sdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q        <= 1'b0;
      sof_q       <= 1'b0;
      locked_q    <= 1'b0;
      pos_q       <= 8'd0;
      acc_q       <= 32'd0;
      sample_o    <= 32'd0;
      chan_o      <= 3'd0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      fs_q        <= fsync_i;
      sof_q       <= tdm_mode_i & fs_rise;
      locked_q    <= lock_now;
      pos_q       <= pos;
      acc_q       <= acc_nxt;
      valid_o     <= emit;
      frame_err_o <= misplaced;
      if (emit) begin
        sample_o <= acc_nxt;
        chan_o   <= ch;
      end
    end
  end

  assert_valid_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_output_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(sample_o) && $stable(chan_o)));

  assert_zero_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((sample_o << wl) == 32'd0));

  assert_quiet_unlocked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_q |=> (!valid_o && !frame_err_o));

  assert_oneline_channels_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !tdm_mode_i && !$past(tdm_mode_i)) |-> ($past(pos_q[6:0]) < 7'd96));
endmodule

// File: tb/octal_audio_deser_tb_top.sv
`timescale 1ns/1ps
module octal_audio_deser_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0, tdm_mode_i = 1'b0, fsync_i = 1'b0, sdata_i = 1'b0;
  logic [2:0] wlen_i = 3'd0;
  logic [31:0] sample_o;
  logic [2:0] chan_o;
  logic valid_o, frame_err_o;

  octal_audio_deser dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tdm_mode_i(tdm_mode_i), .wlen_i(wlen_i),
    .fsync_i(fsync_i), .sdata_i(sdata_i), .sample_o(sample_o), .chan_o(chan_o),
    .valid_o(valid_o), .frame_err_o(frame_err_o));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit run = 0, done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int v_cyc [64]; logic [31:0] v_smp [64]; int v_ch [64]; int vw = 0, vr = 0;
  int e_cyc [64]; int ew = 0, er = 0;

  int m_pos; bit m_lock, m_fsq, m_sof; logic [31:0] m_acc;

  function automatic int wlen_bits(bit tdm, logic [2:0] code);
    int w;
    case (code)
      3'd0: w = 16; 3'd1: w = 18; 3'd2: w = 20; 3'd3: w = 24; default: w = 32;
    endcase
    if (!tdm && w > 24) w = 24;
    return w;
  endfunction

  task automatic drive(bit fs, bit d);
    bit rise, fall, st, hf, lk, ins;
    int nxt, p, ch, b, lastb, off;
    @(negedge clk);
    fsync_i = fs; sdata_i = d;
    rise = fs & !m_fsq; fall = !fs & m_fsq;
    nxt = (m_pos + 1) % 256;
    st = tdm_mode_i ? m_sof : rise;
    hf = !tdm_mode_i & fall;
    p = st ? 0 : (hf ? 128 : nxt);
    if (m_lock && ((st && nxt != 0) || (hf && nxt != 128))) begin
      e_cyc[ew % 64] = cyc + 1; ew++;
    end
    lk = m_lock | st | hf;
    if (tdm_mode_i) begin
      ins = 1; ch = p / 32; b = p % 32; lastb = 31;
    end else begin
      off = p % 128; ins = off < 96; ch = (p / 128) * 4 + off / 24; b = off % 24; lastb = 23;
    end
    if (ins) begin
      if (b == 0) m_acc = 32'd0;
      if (b < wlen_bits(tdm_mode_i, wlen_i)) m_acc[31 - b] = d;
      if (b == lastb && lk) begin
        v_cyc[vw % 64] = cyc + 1; v_smp[vw % 64] = m_acc; v_ch[vw % 64] = ch; vw++;
      end
    end
    m_sof = tdm_mode_i & rise; m_fsq = fs; m_pos = p; m_lock = lk;
  endtask

  always @(negedge clk) if (rst_ni && run) begin
    if (vr != vw && v_cyc[vr % 64] < cyc) begin
      checks++; errors++;
      $display("FAIL R6 missing strobe: actual none expected cycle %0d", v_cyc[vr % 64]); vr++;
    end
    if (valid_o) begin
      checks++;
      if (vr == vw || v_cyc[vr % 64] != cyc) begin
        errors++; $display("FAIL R3/R6 unexpected strobe: actual cycle %0d expected %0d", cyc,
                           (vr == vw) ? -1 : v_cyc[vr % 64]);
      end else begin
        if (sample_o !== v_smp[vr % 64]) begin
          errors++; $display("FAIL R1/R5 sample: actual %h expected %h", sample_o, v_smp[vr % 64]);
        end
        if (int'(chan_o) != v_ch[vr % 64]) begin
          errors++; $display("FAIL R2/R4 channel: actual %0d expected %0d", chan_o, v_ch[vr % 64]);
        end
        vr++;
      end
    end
    if (er != ew && e_cyc[er % 64] < cyc) begin
      checks++; errors++;
      $display("FAIL R7 missing error pulse: actual none expected cycle %0d", e_cyc[er % 64]); er++;
    end
    if (frame_err_o) begin
      checks++;
      if (er == ew || e_cyc[er % 64] != cyc) begin
        errors++; $display("FAIL R7/R8 unexpected error pulse: actual cycle %0d expected %0d", cyc,
                           (er == ew) ? -1 : e_cyc[er % 64]);
      end else er++;
    end
  end

  task automatic drained(string tag);
    checks++;
    if (vr != vw || er != ew) begin
      errors++; $display("FAIL %s pending events: actual %0d expected 0", tag, (vw - vr) + (ew - er));
    end
  endtask

  task automatic do_reset(bit tdm, logic [2:0] code);
    run = 0;
    @(negedge clk); rst_ni = 1'b0; tdm_mode_i = tdm; wlen_i = code; fsync_i = 1'b0;
    m_pos = 0; m_lock = 0; m_fsq = 0; m_sof = 0; m_acc = 0; vw = 0; vr = 0; ew = 0; er = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (sample_o !== 32'd0 || chan_o !== 3'd0 || valid_o !== 1'b0 || frame_err_o !== 1'b0) begin
      errors++; $display("FAIL R8 reset state: actual %h/%0d/%b/%b expected 0", sample_o, chan_o,
                         valid_o, frame_err_o);
    end
    rst_ni = 1'b1; run = 1;
  endtask

  task automatic ol_frame();
    for (int p = 0; p < 256; p++) drive(p < 128, 1'($urandom));
  endtask

  task automatic tdm_frame(int hold);
    for (int p = 0; p < 256; p++) drive(p == 255 || p < hold, 1'($urandom));
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1357));
    do_reset(1'b0, 3'd3);
    for (int i = 0; i < 20; i++) drive(1'b0, 1'($urandom));   // R8 no strobe before alignment
    ol_frame(); ol_frame();
    for (int w = 0; w < 5; w++) begin                          // R2 R3 R5 one-line lengths
      do_reset(1'b0, 3'(w));
      for (int f = 0; f < 2; f++) ol_frame();
      drive(1'b1, 1'($urandom)); drive(1'b1, 1'b0);
      repeat (2) @(negedge clk);
      drained("R2/R3");
    end
    do_reset(1'b0, 3'($urandom_range(0, 3)));                  // R7 one-line misplaced edges
    ol_frame();
    for (int i = 0; i < 40; i++) drive(1'b1, 1'($urandom));
    for (int i = 0; i < 30; i++) drive(1'b0, 1'($urandom));
    ol_frame(); drive(1'b1, 1'b1);
    repeat (2) @(negedge clk);
    drained("R7");
    for (int w = 0; w < 8; w++) begin                          // R4 R5 TDM lengths and widths
      do_reset(1'b1, 3'(w));
      for (int i = 0; i < 10; i++) drive(1'b0, 1'($urandom));
      drive(1'b1, 1'($urandom));
      for (int f = 0; f < 2; f++) tdm_frame($urandom_range(0, 3));
      for (int i = 0; i < 3; i++) drive(1'b0, 1'($urandom));
      repeat (2) @(negedge clk);
      drained("R4/R6");
    end
    do_reset(1'b1, 3'd4);                                      // R7 TDM misplaced pulse
    drive(1'b1, 1'b1);
    tdm_frame(2);
    for (int i = 0; i < 100; i++) drive(1'b0, 1'($urandom));
    drive(1'b1, 1'($urandom));
    tdm_frame(0);
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b0);
    repeat (2) @(negedge clk);
    drained("R7");
    finish_run();
  end
endmodule